// File: doc/BRIEF.md
# Four-Channel ADC Sequencer and Result Framer

This block is the digital control core of a four-channel serial converter interface. The host opens a transfer by pulling chip select low and then gives sixteen serial clocks. On the rising edges it shifts in a control word. At the same time the block shifts out the result word of the conversion made for that transfer. The control word sets the channel for single-channel use, or starts an automatic sequence. That sequence climbs from channel 0 up to a chosen last channel and then wraps back to 0. It keeps running until a rewrite stops it.

The analog converter is modelled by a parallel result input. The block samples that input once per transfer, when chip select falls. It frames the value into a sixteen-bit word that carries the channel tag. All pins are sampled on the block clock: the serial clock, chip select and data in must already be synchronous to it. The result width is a parameter of 8, 10 or 12 bits, and the framer pads the word with trailing zeros.

Top module: `adc_seq_framer`

## Requirements
- R1: The control word is taken MSB first, one bit per rising edge of sclk_i while cs_ni is low. Bit 15 is WRITE, bits 14:13 are the mode code (bit 14 high), bits 12:11 are the address, and bits 10:0 are ignored. The word acts only after the 16th rising edge. Rising edges past the 16th in the same transfer are ignored.
- R2: WRITE=1 with mode 11 starts a sequence. The next transfer converts channel 0, and each later transfer converts the next higher channel, up to and including the written address.
- R3: After the last channel of a running sequence is converted, the next transfer converts channel 0 again, with no new write.
- R4: With WRITE=0 the settings are unchanged. A running sequence keeps stepping, and otherwise the channel stays the same.
- R5: WRITE=1 with mode 10 during a running sequence leaves the sequence, and its last channel, unchanged.
- R6: WRITE=1 with mode 00 or 01, or with mode 10 while no sequence runs, ends any sequence. Every later transfer converts the written address.
- R7: The result word, MSB first, is two zeros, then the 2-bit channel tag, then the result MSB first, then zeros to fill 16 bits.
- R8: data_i and the channel are captured when cs_ni falls. Changes to data_i later in the transfer do not alter the word. ch_sel_o shows the channel for the next transfer.
- R9: If cs_ni rises before 16 rising edges, the control word is discarded and the channel state does not change.
- R10: dout_o carries the word MSB first from the fall of cs_ni, moves one bit on each falling edge of sclk_i, and is low while cs_ni is high.
- R11: After reset no sequence runs, ch_sel_o is 0 and dout_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Transfer frame, active low |
| sclk_i | input | 1 | Serial clock, synchronous to clk_i |
| din_i | input | 1 | Serial control data |
| data_i | input | RES_W | Conversion result of the selected channel |
| dout_o | output | 1 | Serial result word |
| ch_sel_o | output | 2 | Channel for the next conversion |

## Verification
Two decisions can fall on the same control-word completion: the sequencer wrapping from its last channel to 0, and a rewrite that either keeps the sequence (mode 10) or ends it. The bench lands a mode-10 write on the transfer that converts the last channel, and checks that the next tag is 0 with the old last channel still in force. It also lands a mode-01 write on a sequence step and checks that the written address takes over at once. Both outcomes are judged from the channel tag in the next word and from ch_sel_o.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int WORD_W = 16;
  localparam int CH_W   = 2;
  localparam int HDR_W  = 3 + CH_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {
    MODE_FIX0 = 2'b00,
    MODE_FIX1 = 2'b01,
    MODE_KEEP = 2'b10,
    MODE_AUTO = 2'b11
  } seq_mode_e;

  typedef struct packed {
    logic            wr;
    seq_mode_e       mode;
    logic [CH_W-1:0] addr;
  } ctl_hdr_t;
endpackage

// File: rtl/adc_seq_shift.sv
module adc_seq_shift
  import adc_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic [WORD_W-1:0] load_word_i,
  output logic              dout_o,
  output logic              word_valid_o,
  output logic [HDR_W-1:0]  hdr_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);

  logic              sclk_q, cs_q, busy_q, valid_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [WORD_W-1:0] tx_q;
  logic              sclk_rise, sclk_fall, cs_fall;

  assign sclk_rise = sclk_i & ~sclk_q;
  assign sclk_fall = ~sclk_i & sclk_q;
  assign cs_fall   = ~cs_ni & cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
      hdr_q   <= '0;
      tx_q    <= '0;
    end else begin
      sclk_q  <= sclk_i;
      cs_q    <= cs_ni;
      valid_q <= 1'b0;
      if (cs_ni) begin
        busy_q <= 1'b0;
      end else if (cs_fall) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        tx_q   <= load_word_i;
      end else if (busy_q) begin
        if (sclk_rise && cnt_q < CNT_FULL) begin
          cnt_q <= cnt_q + 1'b1;
          // only the leading header bits matter; the rest are dropped
          if (cnt_q < CNT_HDR) hdr_q <= {hdr_q[HDR_W-2:0], din_i};
          if (cnt_q == CNT_LAST) valid_q <= 1'b1;
        end
        if (sclk_fall) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign dout_o       = busy_q & tx_q[WORD_W-1];
  assign word_valid_o = valid_q;
  assign hdr_o        = hdr_q;

  // R1
  valid_one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  // R10
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !cs_ni && !sclk_fall) |=> $stable(tx_q));
  // R9
  no_valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && cs_q) |=> !valid_q);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  ctl_hdr_t        hdr_i,
  output logic [CH_W-1:0] ch_o
);
  logic            run_q;
  logic [CH_W-1:0] last_q, ch_q;
  logic            start_seq, fix_ch;

  assign start_seq = hdr_i.wr && hdr_i.mode == MODE_AUTO;
  assign fix_ch    = hdr_i.wr && !start_seq && !(run_q && hdr_i.mode == MODE_KEEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      last_q <= '0;
      ch_q   <= '0;
    end else if (upd_i) begin
      if (start_seq) begin
        run_q  <= 1'b1;
        last_q <= hdr_i.addr;
        ch_q   <= '0;
      end else if (fix_ch) begin
        run_q  <= 1'b0;
        last_q <= hdr_i.addr;
        ch_q   <= hdr_i.addr;
      end else if (run_q) begin
        ch_q <= (ch_q == last_q) ? '0 : ch_q + 1'b1;
      end
    end
  end

  assign ch_o = ch_q;

  // R2
  auto_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && hdr_i.wr && hdr_i.mode == MODE_AUTO) |=> (run_q && ch_q == '0));
  // R3
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && run_q && ch_q == last_q && (!hdr_i.wr || hdr_i.mode == MODE_KEEP))
    |=> (ch_q == '0 && run_q));
  // R5
  keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && run_q && hdr_i.wr && hdr_i.mode == MODE_KEEP) |=> ($stable(last_q) && run_q));
  // R6
  fix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && hdr_i.wr && (hdr_i.mode == MODE_FIX0 || hdr_i.mode == MODE_FIX1))
    |=> (!run_q && ch_q == $past(hdr_i.addr)));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> ($stable(ch_q) && $stable(run_q) && $stable(last_q)));
endmodule

// File: rtl/adc_seq_frame.sv
module adc_seq_frame
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic [CH_W-1:0]   ch_i,
  input  logic [RES_W-1:0]  data_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int PAD_W = WORD_W - 2 - CH_W - RES_W;

  generate
    if (PAD_W == 0) begin : g_nopad
      assign word_o = {2'b00, ch_i, data_i};
    end else begin : g_pad
      assign word_o = {2'b00, ch_i, data_i, {PAD_W{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/adc_seq_framer.sv
module adc_seq_framer
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic             din_i,
  input  logic [RES_W-1:0] data_i,
  output logic             dout_o,
  output logic [CH_W-1:0]  ch_sel_o
);
  logic [WORD_W-1:0] frame_word;
  logic              word_valid;
  logic [HDR_W-1:0]  hdr_bits;
  ctl_hdr_t          hdr;
  logic [CH_W-1:0]   ch;

  assign hdr = ctl_hdr_t'(hdr_bits);

  adc_seq_frame #(.RES_W(RES_W)) u_frame (
    .ch_i   (ch),
    .data_i (data_i),
    .word_o (frame_word)
  );

  adc_seq_shift u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_ni        (cs_ni),
    .sclk_i       (sclk_i),
    .din_i        (din_i),
    .load_word_i  (frame_word),
    .dout_o       (dout_o),
    .word_valid_o (word_valid),
    .hdr_o        (hdr_bits)
  );

  adc_seq_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (word_valid),
    .hdr_i  (hdr),
    .ch_o   (ch)
  );

  assign ch_sel_o = ch;

  // R10
  dout_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni)) |-> !dout_o);
endmodule

// File: tb/adc_seq_framer_tb.sv
module adc_seq_framer_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1;
  logic        sclk_i = 1'b0;
  logic        din_i = 1'b0;
  logic [11:0] data_i = '0;
  logic        dout_o;
  logic [1:0]  ch_sel_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  adc_seq_framer #(.RES_W(12)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .sclk_i   (sclk_i),
    .din_i    (din_i),
    .data_i   (data_i),
    .dout_o   (dout_o),
    .ch_sel_o (ch_sel_o)
  );

  // {control word, result, expected tag, expected ch_sel after}
  localparam int NVEC = 20;
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h9000, 12'h111, 2'd0, 2'd2},  // R6 fixed addr 2
    {16'h0000, 12'hABC, 2'd2, 2'd2},  // R4 idle hold
    {16'hF000, 12'h123, 2'd2, 2'd0},  // R2 start, last 2
    {16'h7FFF, 12'h456, 2'd0, 2'd1},  // R4 write=0 with junk
    {16'h0000, 12'h789, 2'd1, 2'd2},
    {16'hC000, 12'hFFF, 2'd2, 2'd0},  // R5 keep on last + R3 wrap
    {16'h0000, 12'h001, 2'd0, 2'd1},
    {16'hC000, 12'h800, 2'd1, 2'd2},  // R5 addr ignored
    {16'hB800, 12'h5A5, 2'd2, 2'd3},  // R6 mode 01 stops
    {16'h0000, 12'h0F0, 2'd3, 2'd3},
    {16'hC000, 12'h333, 2'd3, 2'd0},  // R6 mode 10 idle -> fixed 0
    {16'h0000, 12'h444, 2'd0, 2'd0},
    {16'hE000, 12'h555, 2'd0, 2'd0},  // R2 last 0
    {16'h0000, 12'h666, 2'd0, 2'd0},  // R3 wrap on single channel
    {16'hF800, 12'h777, 2'd0, 2'd0},  // R2 restart last 3
    {16'h0000, 12'h888, 2'd0, 2'd1},
    {16'h0000, 12'h999, 2'd1, 2'd2},
    {16'h0000, 12'hAAA, 2'd2, 2'd3},
    {16'h0000, 12'hBBB, 2'd3, 2'd0},  // R3
    {16'h0000, 12'hCCC, 2'd0, 2'd1}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] ctl, input logic [11:0] d, input int nbits,
                      output logic [15:0] got);
    got = '0;
    data_i = d;
    @(negedge clk);
    cs_ni = 1'b0;
    repeat (3) @(negedge clk);
    data_i = ~d;  // R8 late change must not reach the word
    for (int i = 0; i < nbits; i++) begin
      din_i = (i < 16) ? ctl[15-i] : 1'b1;
      repeat (3) @(negedge clk);
      if (i < 16) got[15-i] = dout_o;
      sclk_i = 1'b1;
      repeat (4) @(negedge clk);
      sclk_i = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_ni = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] w;
    repeat (3) @(negedge clk);
    // R11
    check("R11 dout", {15'b0, dout_o}, 16'h0);
    check("R11 ch_sel", {14'b0, ch_sel_o}, 16'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < NVEC; k++) begin
      xfer(VEC[k][31:16], VEC[k][15:4], 16, w);
      // R7 R8 word framing and tag
      check($sformatf("R7 word v%0d", k), w, {2'b00, VEC[k][3:2], VEC[k][15:4]});
      // R2 R3 R4 R5 R6 next channel
      check($sformatf("R8 ch_sel v%0d", k), {14'b0, ch_sel_o}, {14'b0, VEC[k][1:0]});
      // R10 idle low
      check($sformatf("R10 idle v%0d", k), {15'b0, dout_o}, 16'h0);
    end

    // R9 abort after 5 bits of a stop write: nothing changes (sequence at 1, last 3)
    xfer(16'h9000, 12'h321, 5, w);
    check("R9 abort prefix", w[15:11], 5'b00010);
    check("R9 ch_sel", {14'b0, ch_sel_o}, 16'd1);
    xfer(16'h0000, 12'hDDD, 16, w);
    check("R9 sequence continues", w, {4'b0001, 12'hDDD});
    check("R9 step", {14'b0, ch_sel_o}, 16'd2);

    // R1 extra rising edges ignored; fixed addr 2
    xfer(16'h9000, 12'hEEE, 18, w);
    check("R1 word", w, {4'b0010, 12'hEEE});
    check("R1 ch_sel", {14'b0, ch_sel_o}, 16'd2);
    xfer(16'h0000, 12'h0AA, 16, w);
    check("R1 fixed holds", w, {4'b0010, 12'h0AA});
    check("R6 stays fixed", {14'b0, ch_sel_o}, 16'd2);

    // R11 asynchronous reset mid-sequence
    xfer(16'hF800, 12'h010, 16, w);
    xfer(16'h0000, 12'h020, 16, w);
    check("R2 second step", {14'b0, ch_sel_o}, 16'd1);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R11 reset ch_sel", {14'b0, ch_sel_o}, 16'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    xfer(16'h0000, 12'h030, 16, w);
    check("R11 no sequence after reset", w, {4'b0000, 12'h030});
    check("R11 channel held", {14'b0, ch_sel_o}, 16'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule